// File: doc/BRIEF.md
# Masked Multi-Output Coincidence Counter

This block takes a set of already-shaped detector pulses, one per channel, and forms a set of independent coincidence signals. Each coincidence output has its own channel mask. A channel whose mask bit is clear is tied high at that output's AND, so it drops out of the product. The enabled channels must all be high in the same cycle for the output to be high. Any mix from a single channel up to all channels can be chosen per output. A mask of all zeros switches the output off.

The block counts the rising edges of every single channel and of every coincidence signal at the same time, over a gate whose length in clock cycles comes from the configuration port. When the gate expires, every counter is copied into a holding register and restarts from zero in the same cycle. No event is lost between gates. The host then reads the held counts one index at a time.

A small readout state machine tracks the held data and has three states. RD_EMPTY means no unread snapshot. RD_FULL means one unread snapshot. RD_LOST means a snapshot was overwritten before it was read. The transitions are:
- RD_EMPTY goes to RD_FULL on a snapshot.
- RD_FULL goes to RD_EMPTY on read-done and to RD_LOST on a snapshot.
- RD_LOST goes to RD_EMPTY on read-done.
- From RD_FULL or RD_LOST, a snapshot that arrives together with read-done goes to RD_FULL.

Top module: `coinc_counter_top`

## Requirements
- R1: Output o is high in a cycle exactly when its mask `mask_i[o*NCH +: NCH]` is non-zero and every channel whose mask bit is 1 is high. Channels whose bit is 0 have no effect.
- R2: An output whose mask has exactly one bit set counts the same events as that single channel.
- R3: An output whose mask is all zeros never counts, whatever the inputs do.
- R4: Every counter adds one per rising edge of its signal. A signal that stays high for several cycles counts once.
- R5: All NCH single-channel counters and all NOUT coincidence counters run at the same time.
- R6: A counter that reaches 2^CW-1 holds that value until the end of its gate and does not wrap.
- R7: A snapshot is taken every `gate_len_i` cycles; a value of 0 behaves as 1. The snapshot copies every counter, including an edge arriving in that same cycle, and clears the counters. An event stream that crosses a gate boundary is split between the two gates with nothing lost. Held values change only at a snapshot.
- R8: `rd_data_o` shows held count `rd_idx_i` with no clock delay. Indices 0..NCH-1 are the single channels and NCH..NCH+NOUT-1 are coincidence outputs 0..NOUT-1. Any higher index reads 0.
- R9: `ready_o` goes high in the cycle after a snapshot. It goes low in the cycle after `rd_done_i` when no new snapshot coincides.
- R10: A snapshot taken while `ready_o` is high and `rd_done_i` is low overwrites the held data and sets `overrun_o`. `overrun_o` is only high together with `ready_o`, and `rd_done_i` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | NCH | Shaped channel pulses |
| mask_i | input | NOUT*NCH | Channel mask per output, output o in bits o*NCH +: NCH |
| gate_len_i | input | TW | Gate length in clock cycles |
| rd_idx_i | input | $clog2(NCH+NOUT) | Index of the held count to show |
| rd_done_i | input | 1 | One-cycle strobe: readout finished |
| rd_data_o | output | CW | Held count at rd_idx_i |
| ready_o | output | 1 | Unread snapshot present |
| overrun_o | output | 1 | Unread snapshot was overwritten |

## Verification
The checker watches the readout flags on every cycle:
- the set of `ready_o` after a snapshot and its clear after read-done;
- the set of `overrun_o` when a snapshot meets unread data, and that it is sticky;
- that `overrun_o` never appears without `ready_o`;
- that a held value never moves between snapshots.

The count values can only be shown by the bench's scenarios, which compare each held count with a model of the mask rules:
- masked AND forming and disabled outputs;
- counting once per edge on long and overlapping pulses;
- saturation;
- out-of-range indices.

Gate spacing is measured in cycles between two snapshots. A pulse stream laid across a gate boundary shows that its two halves add up to the number of pulses sent.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_FULL  = 2'd1,
        RD_LOST  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/cc_gate_timer.sv
module cc_gate_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] gate_len_i,
    output logic          gate_end_o
);
    logic [TW-1:0] tmr;
    logic [TW:0]   tmr_p1;

    assign tmr_p1     = {1'b0, tmr} + {{TW{1'b0}}, 1'b1};
    // a length of zero expires every cycle, like a length of one
    assign gate_end_o = (tmr_p1 >= {1'b0, gate_len_i});

    always_ff @(posedge clk) begin
        if (!rst_n)          tmr <= '0;
        else if (gate_end_o) tmr <= '0;
        else                 tmr <= tmr_p1[TW-1:0];
    end
endmodule

// File: rtl/cc_match.sv
module cc_match #(
    parameter int NCH  = 20,
    parameter int NOUT = 20
) (
    input  logic [NCH-1:0]      pulse_i,
    input  logic [NOUT*NCH-1:0] mask_i,
    output logic [NOUT-1:0]     coinc_o
);
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic [NCH-1:0] sel;
        logic [NCH-1:0] forced;
        assign sel        = mask_i[o*NCH +: NCH];
        // a channel left out of the mask is driven high into the AND
        assign forced     = pulse_i | ~sel;
        assign coinc_o[o] = (|sel) & (&forced);
    end
endmodule

// File: rtl/cc_edge_counter.sv
module cc_edge_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_i,
    input  logic          snap_i,
    output logic [CW-1:0] hold_o
);
    localparam logic [CW-1:0] CMAX = '1;

    logic          sig_d;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          rise;

    assign rise = sig_i & ~sig_d;

    always_comb begin
        cnt_nxt = cnt;
        if (rise && (cnt != CMAX)) cnt_nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_d  <= 1'b0;
            cnt    <= '0;
            hold_o <= '0;
        end else begin
            sig_d <= sig_i;
            if (snap_i) begin
                hold_o <= cnt_nxt;
                cnt    <= '0;
            end else begin
                cnt <= cnt_nxt;
            end
        end
    end
endmodule

// File: rtl/cc_ready_fsm.sv
module cc_ready_fsm
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic snap_i,
    input  logic done_i,
    output logic ready_o,
    output logic overrun_o
);
    rd_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            RD_EMPTY: if (snap_i) state_nxt = RD_FULL;
            RD_FULL: begin
                if (snap_i)      state_nxt = done_i ? RD_FULL : RD_LOST;
                else if (done_i) state_nxt = RD_EMPTY;
            end
            RD_LOST: begin
                if (snap_i)      state_nxt = done_i ? RD_FULL : RD_LOST;
                else if (done_i) state_nxt = RD_EMPTY;
            end
            default: state_nxt = RD_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        ready_o   = 1'b0;
        overrun_o = 1'b0;
        unique case (state)
            RD_EMPTY: ;
            RD_FULL:  ready_o = 1'b1;
            RD_LOST: begin
                ready_o   = 1'b1;
                overrun_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coinc_counter_top.sv
module coinc_counter_top #(
    parameter int NCH  = 20,
    parameter int NOUT = 20,
    parameter int CW   = 32,
    parameter int TW   = 32,
    localparam int NSIG = NCH + NOUT,
    localparam int IW   = $clog2(NSIG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      pulse_i,
    input  logic [NOUT*NCH-1:0] mask_i,
    input  logic [TW-1:0]       gate_len_i,
    input  logic [IW-1:0]       rd_idx_i,
    input  logic                rd_done_i,
    output logic [CW-1:0]       rd_data_o,
    output logic                ready_o,
    output logic                overrun_o
);
    logic [NCH-1:0]  pulse_q;
    logic [NOUT-1:0] coinc;
    logic [NSIG-1:0] sig_all;
    logic            gate_end;
    logic [CW-1:0]   hold [NSIG];

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_i;
    end

    cc_match #(.NCH(NCH), .NOUT(NOUT)) u_match (
        .pulse_i (pulse_q),
        .mask_i  (mask_i),
        .coinc_o (coinc)
    );

    assign sig_all = {coinc, pulse_q};

    cc_gate_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_len_i (gate_len_i),
        .gate_end_o (gate_end)
    );

    for (genvar s = 0; s < NSIG; s++) begin : g_cnt
        cc_edge_counter #(.CW(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (sig_all[s]),
            .snap_i (gate_end),
            .hold_o (hold[s])
        );
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NSIG; i++) begin
            if (rd_idx_i == IW'(i)) rd_data_o = hold[i];
        end
    end

    cc_ready_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_i    (gate_end),
        .done_i    (rd_done_i),
        .ready_o   (ready_o),
        .overrun_o (overrun_o)
    );
endmodule

// File: rtl/coinc_counter_chk.sv
module coinc_counter_chk #(
    parameter int CW = 32,
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gate_end,
    input logic          rd_done_i,
    input logic [IW-1:0] rd_idx_i,
    input logic [CW-1:0] rd_data_o,
    input logic          ready_o,
    input logic          overrun_o
);
    // R9
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |=> ready_o);

    // R9
    ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done_i && !gate_end) |=> !ready_o);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end && ready_o && !rd_done_i) |=> overrun_o);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !rd_done_i) |=> overrun_o);

    // R10
    overrun_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> ready_o);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> ($stable(rd_data_o) || !$stable(rd_idx_i)));
endmodule

bind coinc_counter_top coinc_counter_chk #(.CW(CW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_end  (gate_end),
    .rd_done_i (rd_done_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .ready_o   (ready_o),
    .overrun_o (overrun_o)
);

// File: tb/coinc_counter_top_test.sv
module coinc_counter_top_test;
    localparam int NCH  = 20;
    localparam int NOUT = 20;
    localparam int CW   = 8;
    localparam int TW   = 32;
    localparam int NSIG = NCH + NOUT;
    localparam int IW   = $clog2(NSIG);
    localparam int GATE = 1000;
    localparam int CMAX = (1 << CW) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCH-1:0]      pulse_i = '0;
    logic [NOUT*NCH-1:0] mask_i = '0;
    logic [TW-1:0]       gate_len_i = TW'(GATE);
    logic [IW-1:0]       rd_idx_i = '0;
    logic                rd_done_i = 1'b0;
    logic [CW-1:0]       rd_data_o;
    logic                ready_o;
    logic                overrun_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int expq[$];
    int exp_cnt[NSIG];
    logic [NCH-1:0] prev_vec = '0;
    bit prev_lvl[NOUT];

    coinc_counter_top #(.NCH(NCH), .NOUT(NOUT), .CW(CW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i), .mask_i(mask_i),
        .gate_len_i(gate_len_i), .rd_idx_i(rd_idx_i), .rd_done_i(rd_done_i),
        .rd_data_o(rd_data_o), .ready_o(ready_o), .overrun_o(overrun_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual running expected done");
        summary();
        $finish;
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] getm(int o);
        return mask_i[o*NCH +: NCH];
    endfunction

    function automatic void bump(int i);
        if (exp_cnt[i] < CMAX) exp_cnt[i]++;
    endfunction

    // driver: apply one cycle of pulses and update the expectation model
    task automatic step(logic [NCH-1:0] vec);
        pulse_i = vec;
        for (int c = 0; c < NCH; c++)
            if (vec[c] && !prev_vec[c]) bump(c);
        for (int o = 0; o < NOUT; o++) begin
            logic [NCH-1:0] m;
            bit lvl;
            m = getm(o);
            lvl = (m != '0) && ((vec & m) == m);
            if (lvl && !prev_lvl[o]) bump(NCH + o);
            prev_lvl[o] = lvl;
        end
        prev_vec = vec;
        @(negedge clk);
    endtask

    task automatic clear_model();
        for (int i = 0; i < NSIG; i++) exp_cnt[i] = 0;
    endtask

    task automatic push_exp();
        for (int i = 0; i < NSIG; i++) expq.push_back(exp_cnt[i]);
        clear_model();
    endtask

    task automatic wait_snap();
        while (!ready_o) @(negedge clk);
    endtask

    task automatic done_pulse();
        rd_done_i = 1'b1;
        @(negedge clk);
        rd_done_i = 1'b0;
    endtask

    // monitor: pop expected counts and compare with the held counts
    task automatic read_gate();
        check_eq("R9", "ready at snapshot", int'(ready_o), 1);
        for (int i = 0; i < NSIG; i++) begin
            string tag;
            int e;
            rd_idx_i = IW'(i);
            @(negedge clk);
            e = expq.pop_front();
            if (i < NCH) tag = "R5";
            else if (i == NCH + 5) tag = "R3";
            else if (i == NCH || i == NCH + 1) tag = "R2";
            else tag = "R1";
            check_eq(tag, $sformatf("count idx %0d", i), int'(rd_data_o), e);
        end
        done_pulse();
        check_eq("R9", "ready after done", int'(ready_o), 0);
        check_eq("R10", "overrun after done", int'(overrun_o), 0);
    endtask

    task automatic read_idx(int i, output int v);
        rd_idx_i = IW'(i);
        @(negedge clk);
        v = int'(rd_data_o);
    endtask

    initial begin
        int v, a, b, t1, t2;
        for (int o = 0; o < NOUT; o++) begin
            logic [NCH-1:0] m;
            case (o)
                0: m = NCH'(1);
                1: m = NCH'(1) << 5;
                2: m = NCH'(3);
                3: m = NCH'(7);
                4: m = '1;
                5: m = '0;
                6: m = (NCH'(1) << 3) | (NCH'(1) << 7);
                default: m = (NCH'(1) << o) | (NCH'(1) << (o - 7));
            endcase
            mask_i[o*NCH +: NCH] = m;
        end
        repeat (5) @(negedge clk);
        check_eq("R9", "ready in reset", int'(ready_o), 0);
        check_eq("R10", "overrun in reset", int'(overrun_o), 0);
        check_eq("R8", "data in reset", int'(rd_data_o), 0);
        rst_n = 1'b1;
        clear_model();
        push_exp();

        // gate 0 readout, then singles and repeats (R2, R5)
        wait_snap(); read_gate();
        for (int c = 0; c < NCH; c++) begin step(NCH'(1) << c); step('0); end
        repeat (3) begin step(NCH'(1) << 5); step('0); end
        push_exp();

        // masked AND patterns including twentyfold (R1)
        wait_snap(); read_gate();
        step('1); step('0);
        step(NCH'(3)); step('0);
        step(NCH'(15)); step('0);
        step((NCH'(1) << 3) | (NCH'(1) << 7) | (NCH'(1) << 10)); step('0);
        push_exp();

        // long and overlapping pulses (R4)
        wait_snap(); read_gate();
        repeat (10) step((NCH'(1) << 3) | (NCH'(1) << 7));
        step('0);
        repeat (3) step(NCH'(1) << 3);
        repeat (3) step((NCH'(1) << 3) | (NCH'(1) << 7));
        repeat (3) step(NCH'(1) << 7);
        step('0);
        push_exp();

        wait_snap(); read_gate();
        read_idx(NCH + 6, v); check_eq("R4", "multi-cycle once out6", v, 2);
        read_idx(3, v); check_eq("R4", "multi-cycle once ch3", v, 2);

        // saturation (R6)
        repeat (300) begin step(NCH'(1)); step('0); end
        push_exp();
        wait_snap(); read_gate();
        read_idx(0, v); check_eq("R6", "saturated ch0", v, CMAX);
        read_idx(NCH, v); check_eq("R6", "saturated out0", v, CMAX);
        read_idx(NSIG, v); check_eq("R8", "index beyond range", v, 0);
        read_idx((1 << IW) - 1, v); check_eq("R8", "top index", v, 0);

        // overrun: first snapshot left unread (R10), gate spacing (R7)
        step(NCH'(1) << 2); step('0);
        clear_model();
        wait_snap(); t1 = cyc;
        check_eq("R10", "no overrun yet", int'(overrun_o), 0);
        step(NCH'(1) << 9); step('0);
        push_exp();
        while (!overrun_o) @(negedge clk);
        t2 = cyc;
        check_eq("R10", "overrun set", int'(overrun_o), 1);
        check_eq("R10", "ready with overrun", int'(ready_o), 1);
        check_eq("R7", "gate spacing", t2 - t1, GATE);
        read_gate();

        // pulse stream across a gate boundary (R7)
        repeat (450) @(negedge clk);
        fork
            begin
                repeat (200) begin
                    pulse_i = NCH'(1) << 1;
                    @(negedge clk);
                    pulse_i = '0;
                    repeat (3) @(negedge clk);
                end
            end
            begin
                wait_snap();
                read_idx(1, a);
                done_pulse();
            end
        join
        wait_snap();
        read_idx(1, b);
        done_pulse();
        check_eq("R7", "split across boundary", a + b, 200);
        check_eq("R7", "first part nonzero", int'(a > 0), 1);
        check_eq("R7", "second part nonzero", int'(b > 0), 1);

        summary();
        $finish;
    end
endmodule